// File: doc/BRIEF.md
# Bridge Read Fetch Planner

This block sits in a bus bridge and decides, for each conventional memory read request that arrives on one side, how the request is forwarded to the other side. It chooses between two forwarded command forms: a single-DWORD read or a block read. It also works out how many bytes the block read should fetch. The caller supplies the request kind (plain read, read line or read multiple), the start address and the side it came from. The caller also supplies the bounds of the prefetchable address window, the cache line size in DWORDs and a 32-bit prefetch control word.

The control word holds a separate 2-bit prefetch policy for each request kind on each side, plus a 3-bit cap field. The policy field is selected by the request kind and the originating side. A policy can ask for one DWORD, for data up to the end of the current cache line, or for a full prefetch up to the cap. The result is always clipped so that it never runs past the top of the prefetchable window. The suggested reset value of the control word is 0x0160_3160. With that value, plain reads and read-line requests fetch up to one cache line, and read-multiple requests fetch up to 512 bytes, which is one whole read buffer.

Both results are registered. They appear one clock after the request strobe and are held until the next request.

Top module: `rd_fetch_planner`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise. Without a request, `out_bytes` and `out_block` keep their last values.
- R2: While `rst_n` is low, `out_valid`, `out_block` and `out_bytes` are all 0.
- R3: The two low address bits are ignored, so the DWORD-aligned address is used. An aligned address is prefetchable when `win_lo <= address < win_hi`, with both bounds DWORD aligned. A request outside the window yields `out_bytes` = 4, whatever the request kind or the policy.
- R4: `req_cmd` encodes 0 = plain read, 1 = read line, 2 = read multiple and 3 = treated as a plain read. `out_block` is 0 (single-DWORD read) only for a plain read outside the window. It is 1 (block read) in every other case.
- R5: `req_side` = 1 (secondary) takes its policy from `ctrl` bits 25:24 (plain read), 23:22 (read line) and 21:20 (read multiple). `req_side` = 0 (primary) takes it from bits 9:8, 7:6 and 5:4 respectively.
- R6: Policy 0 yields `out_bytes` = 4.
- R7: Policy 1, and policy 3 (which behaves as policy 1), fetch up to the next cache-line boundary. The count is L − (address mod L), where L = 4 × `line_dw` and `line_dw` is a power of two. When `line_dw` is 0, the count is 4.
- R8: Policy 2 fetches 64 << `ctrl[14:12]` bytes.
- R9: Inside the window, the byte count is clipped to `win_hi` − address. The count is never below 4 and is always a multiple of 4.
- R10: With `ctrl` = 0x0160_3160, a read multiple fetches 512 bytes, and plain reads and read-line requests fetch up to the end of the cache line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_cmd | input | 2 | Request kind |
| req_side | input | 1 | Originating side: 0 primary, 1 secondary |
| req_addr | input | ADDR_W | Start byte address |
| win_lo | input | ADDR_W | Lowest prefetchable byte address |
| win_hi | input | ADDR_W | First address above the prefetchable window |
| line_dw | input | LINE_W | Cache line size in DWORDs |
| ctrl | input | CTRL_W | Prefetch control word |
| out_valid | output | 1 | Result strobe |
| out_block | output | 1 | 1 = block read, 0 = single-DWORD read |
| out_bytes | output | LEN_W | Byte count to request |

## Verification
Every result is due exactly one rising edge after the request edge. `out_valid`, `out_block` and `out_bytes` all pass through a single register stage and have no other latency. The bench changes inputs on the falling edge and samples the outputs on the next falling edge, so each request is checked after one rising edge, even when requests are issued back to back. Idle cycles are sampled the same way to confirm that the strobe drops and the held values do not move.

// File: rtl/rfp_pkg.sv
`timescale 1ns/1ps
package rfp_pkg;

   typedef enum logic [1:0] {
      RD_PLAIN = 2'd0,
      RD_LINE  = 2'd1,
      RD_MULTI = 2'd2,
      RD_ALIAS = 2'd3
   } rd_kind_e;

   typedef enum logic [1:0] {
      PF_ONE_DW  = 2'd0,
      PF_TO_LINE = 2'd1,
      PF_TO_CAP  = 2'd2,
      PF_SPARE   = 2'd3
   } pf_mode_e;

   localparam int unsigned N_KINDS  = 3;
   localparam int unsigned MODE_W   = 2;
   localparam int unsigned DW_BYTES = 4;

endpackage

// File: rtl/rfp_mode_select.sv
`timescale 1ns/1ps
module rfp_mode_select
   import rfp_pkg::*;
#(
   parameter int unsigned CTRL_W      = 32,
   parameter int unsigned PRI_TOP_LSB = 8,
   parameter int unsigned SEC_TOP_LSB = 24,
   parameter int unsigned LIM_LSB     = 12,
   parameter int unsigned LIM_W       = 3
) (
   input  logic [CTRL_W-1:0] ctrl,
   input  logic              side_sec,
   input  rd_kind_e          kind,
   output pf_mode_e          mode,
   output logic [LIM_W-1:0]  lim
);

   logic [MODE_W-1:0] pri_f [N_KINDS];
   logic [MODE_W-1:0] sec_f [N_KINDS];
   logic [MODE_W-1:0] pri_sel;
   logic [MODE_W-1:0] sec_sel;
   logic              unused_ctrl;

   // one field per request kind, fields step down by MODE_W from the top one
   for (genvar k = 0; k < N_KINDS; k++) begin : g_field
      assign pri_f[k] = ctrl[PRI_TOP_LSB - MODE_W*k +: MODE_W];
      assign sec_f[k] = ctrl[SEC_TOP_LSB - MODE_W*k +: MODE_W];
   end

   always_comb begin
      case (kind)
         RD_LINE: begin
            pri_sel = pri_f[1];
            sec_sel = sec_f[1];
         end
         RD_MULTI: begin
            pri_sel = pri_f[2];
            sec_sel = sec_f[2];
         end
         default: begin
            pri_sel = pri_f[0];
            sec_sel = sec_f[0];
         end
      endcase
      mode = pf_mode_e'(side_sec ? sec_sel : pri_sel);
   end

   assign lim         = ctrl[LIM_LSB +: LIM_W];
   assign unused_ctrl = ^ctrl;

endmodule

// File: rtl/rfp_window_check.sv
`timescale 1ns/1ps
module rfp_window_check #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] win_lo,
   input  logic [ADDR_W-1:0] win_hi,
   output logic [ADDR_W-1:0] addr_al,
   output logic              in_win,
   output logic [ADDR_W-1:0] room
);

   assign addr_al = addr & ~ADDR_W'(3);
   assign in_win  = (addr_al >= win_lo) && (addr_al < win_hi);
   assign room    = win_hi - addr_al;

endmodule

// File: rtl/rfp_length_calc.sv
`timescale 1ns/1ps
module rfp_length_calc
   import rfp_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned LINE_W       = 8,
   parameter int unsigned LIM_W        = 3,
   parameter int unsigned CAP_MIN_LOG2 = 6,
   parameter int unsigned LEN_W        = 14,
   parameter int unsigned LB_W         = LINE_W + 2
) (
   input  pf_mode_e          mode,
   input  logic [LIM_W-1:0]  lim,
   input  logic              in_win,
   input  logic [ADDR_W-1:0] room,
   input  logic [LB_W-1:0]   addr_lo,
   input  logic [LINE_W-1:0] line_dw,
   output logic [LEN_W-1:0]  bytes
);

   logic [LB_W-1:0]  line_bytes;
   logic [LB_W-1:0]  line_off;
   logic [LB_W-1:0]  to_line;
   logic [LEN_W-1:0] cap;
   logic [LEN_W-1:0] raw;

   assign line_bytes = {line_dw, 2'b00};
   assign line_off   = addr_lo & (line_bytes - LB_W'(1));
   assign to_line    = (line_dw == '0) ? LB_W'(DW_BYTES) : (line_bytes - line_off);
   assign cap        = LEN_W'(2 ** CAP_MIN_LOG2) << lim;

   always_comb begin
      case (mode)
         PF_ONE_DW: raw = LEN_W'(DW_BYTES);
         PF_TO_CAP: raw = cap;
         default:   raw = LEN_W'(to_line);
      endcase
   end

   always_comb begin
      if (!in_win)
         bytes = LEN_W'(DW_BYTES);
      else if (room < ADDR_W'(raw))
         bytes = LEN_W'(room);
      else
         bytes = raw;
   end

endmodule

// File: rtl/rd_fetch_planner.sv
`timescale 1ns/1ps
module rd_fetch_planner
   import rfp_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned LINE_W       = 8,
   parameter int unsigned CTRL_W       = 32,
   parameter int unsigned PRI_TOP_LSB  = 8,
   parameter int unsigned SEC_TOP_LSB  = 24,
   parameter int unsigned LIM_LSB      = 12,
   parameter int unsigned LIM_W        = 3,
   parameter int unsigned CAP_MIN_LOG2 = 6,
   localparam int unsigned LEN_W       = CAP_MIN_LOG2 + 2 ** LIM_W,
   localparam int unsigned LB_W        = LINE_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_cmd,
   input  logic              req_side,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ADDR_W-1:0] win_lo,
   input  logic [ADDR_W-1:0] win_hi,
   input  logic [LINE_W-1:0] line_dw,
   input  logic [CTRL_W-1:0] ctrl,
   output logic              out_valid,
   output logic              out_block,
   output logic [LEN_W-1:0]  out_bytes
);

   // elaboration-time parameter checks
   if (LEN_W < LB_W) begin : g_bad_line_w
      $error("rd_fetch_planner: cache line span does not fit the length width");
   end
   if (ADDR_W < LEN_W) begin : g_bad_addr_w
      $error("rd_fetch_planner: address narrower than length width");
   end
   if (PRI_TOP_LSB < MODE_W * (N_KINDS - 1) || SEC_TOP_LSB < MODE_W * (N_KINDS - 1)) begin : g_bad_lsb
      $error("rd_fetch_planner: policy fields would start below bit 0");
   end
   if (PRI_TOP_LSB + MODE_W > CTRL_W || SEC_TOP_LSB + MODE_W > CTRL_W
       || LIM_LSB + LIM_W > CTRL_W) begin : g_bad_ctrl_w
      $error("rd_fetch_planner: control fields exceed control width");
   end
   if (CAP_MIN_LOG2 < 2) begin : g_bad_cap
      $error("rd_fetch_planner: smallest cap must be at least one DWORD");
   end

   rd_kind_e          kind;
   pf_mode_e          mode;
   logic [LIM_W-1:0]  lim;
   logic [ADDR_W-1:0] addr_al;
   logic              in_win;
   logic [ADDR_W-1:0] room;
   logic [LEN_W-1:0]  nxt_bytes;
   logic              nxt_block;

   assign kind = rd_kind_e'(req_cmd);

   rfp_mode_select #(
      .CTRL_W      (CTRL_W),
      .PRI_TOP_LSB (PRI_TOP_LSB),
      .SEC_TOP_LSB (SEC_TOP_LSB),
      .LIM_LSB     (LIM_LSB),
      .LIM_W       (LIM_W)
   ) i_mode_select (
      .ctrl     (ctrl),
      .side_sec (req_side),
      .kind     (kind),
      .mode     (mode),
      .lim      (lim)
   );

   rfp_window_check #(
      .ADDR_W (ADDR_W)
   ) i_window_check (
      .addr    (req_addr),
      .win_lo  (win_lo),
      .win_hi  (win_hi),
      .addr_al (addr_al),
      .in_win  (in_win),
      .room    (room)
   );

   rfp_length_calc #(
      .ADDR_W       (ADDR_W),
      .LINE_W       (LINE_W),
      .LIM_W        (LIM_W),
      .CAP_MIN_LOG2 (CAP_MIN_LOG2),
      .LEN_W        (LEN_W),
      .LB_W         (LB_W)
   ) i_length_calc (
      .mode    (mode),
      .lim     (lim),
      .in_win  (in_win),
      .room    (room),
      .addr_lo (addr_al[LB_W-1:0]),
      .line_dw (line_dw),
      .bytes   (nxt_bytes)
   );

   // only a plain read to non-prefetchable space stays a single-DWORD read
   assign nxt_block = in_win || (kind == RD_LINE) || (kind == RD_MULTI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_block <= 1'b0;
         out_bytes <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            out_block <= nxt_block;
            out_bytes <= nxt_bytes;
         end
      end
   end

endmodule

// File: rtl/rfp_checker.sv
`timescale 1ns/1ps
module rfp_checker #(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned LEN_W        = 14,
   parameter int unsigned CAP_MIN_LOG2 = 6,
   parameter int unsigned LIM_W        = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_cmd,
   input logic [ADDR_W-1:0] req_addr,
   input logic [ADDR_W-1:0] win_lo,
   input logic [ADDR_W-1:0] win_hi,
   input logic              out_valid,
   input logic              out_block,
   input logic [LEN_W-1:0]  out_bytes
);

   localparam int unsigned MAX_CAP = 1 << (CAP_MIN_LOG2 + 2 ** LIM_W - 1);

   logic [ADDR_W-1:0] chk_al;
   logic              chk_in;
   logic [ADDR_W-1:0] chk_room;

   assign chk_al   = req_addr & ~ADDR_W'(3);
   assign chk_in   = (chk_al >= win_lo) && (chk_al < win_hi);
   assign chk_room = win_hi - chk_al;

   AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid); // R1
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid); // R1
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(out_bytes) && $stable(out_block))); // R1
   AST_OUTSIDE_ONE_DW: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !chk_in) |=> (out_bytes == LEN_W'(4))); // R3
   AST_DWORD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !chk_in && (req_cmd == 2'd0 || req_cmd == 2'd3)) |=> !out_block); // R4
   AST_BLOCK_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (chk_in || req_cmd == 2'd1 || req_cmd == 2'd2)) |=> out_block); // R4
   AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_bytes <= LEN_W'(MAX_CAP))); // R8
   AST_WINDOW_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && chk_in) |=> (ADDR_W'(out_bytes) <= $past(chk_room))); // R9
   AST_MIN_DWORD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_bytes >= LEN_W'(4) && out_bytes[1:0] == 2'b00)); // R9

endmodule

bind rd_fetch_planner rfp_checker #(
   .ADDR_W       (ADDR_W),
   .LEN_W        (LEN_W),
   .CAP_MIN_LOG2 (CAP_MIN_LOG2),
   .LIM_W        (LIM_W)
) i_rfp_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_cmd   (req_cmd),
   .req_addr  (req_addr),
   .win_lo    (win_lo),
   .win_hi    (win_hi),
   .out_valid (out_valid),
   .out_block (out_block),
   .out_bytes (out_bytes)
);

// File: tb/test_rd_fetch_planner.sv
`timescale 1ns/1ps
module test_rd_fetch_planner;

   localparam logic [31:0] WLO = 32'h0000_1000;
   localparam logic [31:0] WHI = 32'h0000_2000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_cmd = 2'd0;
   logic        req_side = 1'b0;
   logic [31:0] req_addr = 32'h0;
   logic [31:0] win_lo = WLO;
   logic [31:0] win_hi = WHI;
   logic [7:0]  line_dw = 8'd8;
   logic [31:0] ctrl = 32'h0;
   logic        out_valid;
   logic        out_block;
   logic [13:0] out_bytes;

   int     n_chk = 0;
   int     n_err = 0;
   longint last_bytes = 0;
   bit     last_block = 1'b0;

   always #2.5 clk = ~clk;

   rd_fetch_planner i_rd_fetch_planner (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_cmd   (req_cmd),
      .req_side  (req_side),
      .req_addr  (req_addr),
      .win_lo    (win_lo),
      .win_hi    (win_hi),
      .line_dw   (line_dw),
      .ctrl      (ctrl),
      .out_valid (out_valid),
      .out_block (out_block),
      .out_bytes (out_bytes)
   );

   task automatic check(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d (cmd=%0d side=%0d addr=%h ctrl=%h line=%0d)",
                  tag, act, exp, req_cmd, req_side, req_addr, ctrl, line_dw);
      end
   endtask

   function automatic bit outside(logic [31:0] addr);
      longint a;
      a = longint'(addr & 32'hFFFF_FFFC);
      return (a < longint'(WLO)) || (a >= longint'(WHI));
   endfunction

   // expected byte count straight from the requirement text
   function automatic longint model_bytes(bit side, int cmd, logic [31:0] c,
                                          logic [31:0] addr, int line, output string tag);
      longint a, len, room, lb;
      int     idx, lsb, m, lim;
      a = longint'(addr & 32'hFFFF_FFFC);
      if (outside(addr)) begin
         tag = "R3";
         return 4;
      end
      idx = (cmd == 3) ? 0 : cmd;
      lsb = (side ? 24 : 8) - 2 * idx;
      m   = int'((c >> lsb) & 32'h3);
      lim = int'((c >> 12) & 32'h7);
      if (m == 0) begin
         tag = "R6";
         len = 4;
      end else if (m == 2) begin
         tag = "R8";
         len = longint'(64) << lim;
      end else begin
         tag = "R7";
         if (line == 0) len = 4;
         else begin
            lb  = longint'(line) * 4;
            len = lb - (a % lb);
         end
      end
      room = longint'(WHI) - a;
      if (room < len) begin
         tag = "R9";
         len = room;
      end
      return len;
   endfunction

   function automatic logic [31:0] make_ctrl(bit side, int cmd, int mode, int lim);
      logic [31:0] c;
      int          other, idx;
      c     = 32'h0;
      other = (mode + 1) % 4;
      for (int s = 0; s < 2; s++)
         for (int k = 0; k < 3; k++)
            c[((s != 0) ? 24 : 8) - 2 * k +: 2] = other[1:0];
      idx = (cmd == 3) ? 0 : cmd;
      c[(side ? 24 : 8) - 2 * idx +: 2] = mode[1:0];
      c[14:12] = lim[2:0];
      return c;
   endfunction

   // called at a falling edge; leaves at the next falling edge after checking
   task automatic apply(bit side, int cmd, logic [31:0] c, logic [31:0] addr,
                        int line, string force_tag);
      string  tag;
      longint eb;
      bit     eblk;
      req_valid = 1'b1;
      req_side  = side;
      req_cmd   = cmd[1:0];
      ctrl      = c;
      req_addr  = addr;
      line_dw   = line[7:0];
      eb   = model_bytes(side, cmd, c, addr, line, tag);
      eblk = !(outside(addr) && (cmd == 0 || cmd == 3));
      if (force_tag != "") tag = force_tag;
      @(negedge clk);
      check("R1", longint'(out_valid), 1);
      check(tag, longint'(out_bytes), eb);
      check("R4", longint'(out_block), longint'(eblk));
      last_bytes = eb;
      last_block = eblk;
   endtask

   initial begin : watchdog
      #1000000;
      n_err++;
      n_chk++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      logic [31:0] addrs [9];
      int          lines [4];
      addrs = '{32'h0000_0FFC, 32'h0000_1000, 32'h0000_1013, 32'h0000_10F0, 32'h0000_1234,
                32'h0000_1E40, 32'h0000_1FF8, 32'h0000_1FFF, 32'h0000_2000};
      lines = '{0, 1, 8, 16};

      // R2: reset state
      req_valid = 1'b1;
      repeat (3) @(negedge clk);
      check("R2", longint'(out_valid), 0);
      check("R2", longint'(out_block), 0);
      check("R2", longint'(out_bytes), 0);
      req_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", longint'(out_valid), 0);

      // R5: side selects its own field; kind 3 uses the plain-read field
      apply(1'b0, 0, 32'h0200_0000, WLO, 8, "R5");
      apply(1'b1, 0, 32'h0200_0000, WLO, 8, "R5");
      apply(1'b1, 3, 32'h0200_0000, WLO, 8, "R5");
      apply(1'b0, 2, 32'h0000_0020, WLO, 8, "R5");
      apply(1'b1, 2, 32'h0000_0020, WLO, 8, "R5");

      // R10: suggested reset value of the control word
      apply(1'b0, 2, 32'h0160_3160, WLO, 16, "R10");
      apply(1'b1, 2, 32'h0160_3160, 32'h0000_1100, 16, "R10");
      apply(1'b0, 0, 32'h0160_3160, 32'h0000_1010, 16, "R10");
      apply(1'b1, 1, 32'h0160_3160, 32'h0000_1004, 16, "R10");

      // sweep of side, kind, policy, cap, address and line size (R3..R9)
      for (int s = 0; s < 2; s++)
         for (int cm = 0; cm < 4; cm++)
            for (int md = 0; md < 4; md++)
               for (int lm = 0; lm < 8; lm++)
                  for (int ai = 0; ai < 9; ai++)
                     for (int li = 0; li < 4; li++)
                        apply(s[0], cm, make_ctrl(s[0], cm, md, lm), addrs[ai], lines[li], "");

      // R1: idle cycles drop the strobe and hold the results
      req_valid = 1'b0;
      req_addr  = 32'h0000_1200;
      ctrl      = 32'h0000_7020;
      @(negedge clk);
      check("R1", longint'(out_valid), 0);
      check("R1", longint'(out_bytes), last_bytes);
      check("R1", longint'(out_block), longint'(last_block));
      req_cmd = 2'd2;
      @(negedge clk);
      check("R1", longint'(out_valid), 0);
      check("R1", longint'(out_bytes), last_bytes);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule